// File: doc/BRIEF.md
# Combinational ALU with Zero, Carry and Sign Flags

This block is a single-level arithmetic-logic unit with no clock and no state. It takes two operands of a parameterised width and a 4-bit operation code. It returns the result and three status flags in the same combinational path. A datapath instantiates it between its operand registers and its result register. The 12 operations cover moves, add and subtract with carry or borrow, step by one in either direction, a product truncated to the operand width, bitwise logic, and single-position logical shifts.

All four adder-based operations share one adder with a carry-in. The multiply output keeps only the low half of the product. The flags are derived from the selected result, so they always describe what is on the result port. Codes outside the defined set give a quiet output: result zero and every flag clear.

Top module: `flag_alu`

## Requirements
- R1: Code 0 (pass) drives `res` with `op_a` unchanged.
- R2: Code 1 (add) gives `op_a + op_b` modulo 2^WIDTH and sets carry (flags bit 1) when the true sum needs WIDTH+1 bits. Code 2 (subtract) gives `op_a - op_b` modulo 2^WIDTH and sets carry as a borrow when `op_a < op_b` unsigned.
- R3: Code 3 (increment) gives `op_a + 1` with carry set only when `op_a` is all ones. Code 4 (decrement) gives `op_a - 1` with carry set as a borrow only when `op_a` is zero.
- R4: Code 5 (multiply) drives `res` with the low WIDTH bits of the full double-width unsigned product.
- R5: Codes 6, 7 and 8 give the bitwise AND, OR and XOR of the two operands.
- R6: Code 9 gives the bitwise inverse of `op_a`.
- R7: Code 10 shifts `op_a` left by one position and code 11 shifts it right by one position. Both shifts are logical: the vacated bit is 0 and the bit shifted out is lost.
- R8: For codes 0 to 11, the zero flag (flags bit 0) is 1 exactly when `res` is all zeros.
- R9: The sign flag (flags bit 2) always equals the most significant bit of `res`.
- R10: The carry flag is 0 for every code other than 1, 2, 3 and 4.
- R11: Codes 12 to 15 give `res` = 0 and `flags` = 3'b000. The zero flag is clear even though the result is zero.
- R12: For codes 0, 3, 4, 9, 10 and 11, `op_b` has no effect on `res` or `flags`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | First operand; the only operand of the unary codes |
| op_b | input | WIDTH | Second operand |
| op_sel | input | 4 | Operation code, 0 to 11 defined, 12 to 15 quiet |
| res | output | WIDTH | Result of the selected operation |
| flags | output | 3 | {sign, carry, zero} |

## Verification
The bench builds two copies of the block.

The first uses the default width of 32 bits. Directed cases there cover the full-width boundaries:
- an add that overflows past bit 31;
- increment of all ones and decrement of zero;
- a product whose low half is zero or one;
- shifts that push a bit off either end.

The second copy is built with WIDTH = 8. At that width every value of `op_a` can be swept under all 16 codes against a reference model. This reaches every carry, borrow, sign and zero transition of the narrow datapath and every undefined code.

// File: rtl/flag_alu_pkg.sv
// Package: shared operation codes and flag positions for flag_alu.
// Assumes a 4-bit operation code; codes above OP_SHR are treated as undefined.
package flag_alu_pkg;

    localparam int OP_W      = 4;
    localparam int FLAG_W    = 3;
    localparam int FLAG_ZERO = 0;
    localparam int FLAG_CARRY = 1;
    localparam int FLAG_SIGN = 2;

    typedef enum logic [OP_W-1:0] {
        OP_PASS = 4'd0,
        OP_ADD  = 4'd1,
        OP_SUB  = 4'd2,
        OP_INC  = 4'd3,
        OP_DEC  = 4'd4,
        OP_MUL  = 4'd5,
        OP_AND  = 4'd6,
        OP_OR   = 4'd7,
        OP_XOR  = 4'd8,
        OP_NOT  = 4'd9,
        OP_SHL  = 4'd10,
        OP_SHR  = 4'd11
    } alu_op_e;

    localparam logic [OP_W-1:0] OP_LAST = 4'd11;

    // Which result source a code selects in the final multiplexer.
    typedef enum logic [1:0] {
        SRC_ARITH = 2'd0,
        SRC_MUL   = 2'd1,
        SRC_BIT   = 2'd2,
        SRC_NONE  = 2'd3
    } res_src_e;

    // True for the defined codes.
    function automatic logic op_is_defined(input logic [OP_W-1:0] code);
        return code <= OP_LAST;
    endfunction

    // True for the codes that use the shared adder and report a carry.
    function automatic logic op_uses_adder(input logic [OP_W-1:0] code);
        return (code == OP_ADD) || (code == OP_SUB) ||
               (code == OP_INC) || (code == OP_DEC);
    endfunction

endpackage

// File: rtl/flag_alu_arith.sv
// Module: flag_alu_arith
// Serves add, subtract, increment and decrement with one WIDTH+1 bit adder.
// The second adder input and the carry-in are chosen per code.
// For subtract and decrement, the carry output is inverted so that it reads
// as a borrow. Assumes the caller ignores its outputs for other codes.
module flag_alu_arith
    import flag_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  alu_op_e          op,
    output logic [WIDTH-1:0] sum,
    output logic             carry
);

    localparam int SUM_W = WIDTH + 1;

    logic [WIDTH-1:0] addend;
    logic             cin;
    logic             borrow_mode;
    logic [SUM_W-1:0] total;

    // Pick the second adder input and carry-in for the requested code.
    always_comb begin
        addend      = opnd_b;
        cin         = 1'b0;
        borrow_mode = 1'b0;
        case (op)
            OP_ADD: begin
                addend = opnd_b;
                cin    = 1'b0;
            end
            OP_SUB: begin
                addend      = ~opnd_b;
                cin         = 1'b1;
                borrow_mode = 1'b1;
            end
            OP_INC: begin
                addend = '0;
                cin    = 1'b1;
            end
            OP_DEC: begin
                addend      = '1;
                cin         = 1'b0;
                borrow_mode = 1'b1;
            end
            default: begin
                addend = opnd_b;
                cin    = 1'b0;
            end
        endcase
    end

    // One shared adder with a carry-out bit.
    always_comb begin
        total = {1'b0, opnd_a} + {1'b0, addend} + SUM_W'(cin);
    end

    // Split the sum and turn the carry into a borrow where needed.
    always_comb begin
        sum   = total[WIDTH-1:0];
        carry = total[WIDTH] ^ borrow_mode;
    end

endmodule

// File: rtl/flag_alu_mul.sv
// Module: flag_alu_mul
// Unsigned multiplier that returns the low WIDTH bits of the product.
// The low half of the double-width product does not depend on the upper
// half, so only WIDTH result bits are formed. Purely combinational.
module flag_alu_mul #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    output logic [WIDTH-1:0] prod_lo
);

    // Multiply in a WIDTH-bit context, which truncates to the low half.
    always_comb begin
        prod_lo = opnd_a * opnd_b;
    end

endmodule

// File: rtl/flag_alu_bitwise.sv
// Module: flag_alu_bitwise
// Serves pass, AND, OR, XOR, NOT and the two single-position logical shifts.
// Shifts fill the vacated bit with zero. Assumes WIDTH >= 2.
module flag_alu_bitwise
    import flag_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  alu_op_e          op,
    output logic [WIDTH-1:0] out
);

    logic [WIDTH-1:0] shl_v;
    logic [WIDTH-1:0] shr_v;

    // Build both shifted copies bit by bit.
    for (genvar i = 0; i < WIDTH; i++) begin : g_shift
        if (i == 0) begin : g_lsb
            assign shl_v[i] = 1'b0;
        end else begin : g_mid_l
            assign shl_v[i] = opnd_a[i-1];
        end
        if (i == WIDTH - 1) begin : g_msb
            assign shr_v[i] = 1'b0;
        end else begin : g_mid_r
            assign shr_v[i] = opnd_a[i+1];
        end
    end

    // Select the logic result for the requested code.
    always_comb begin
        case (op)
            OP_PASS: out = opnd_a;
            OP_AND:  out = opnd_a & opnd_b;
            OP_OR:   out = opnd_a | opnd_b;
            OP_XOR:  out = opnd_a ^ opnd_b;
            OP_NOT:  out = ~opnd_a;
            OP_SHL:  out = shl_v;
            OP_SHR:  out = shr_v;
            default: out = '0;
        endcase
    end

endmodule

// File: rtl/flag_alu.sv
// Module: flag_alu (top)
// Combinational ALU with 12 operations and a {sign, carry, zero} flag vector.
// Codes 12..15 give a zero result with every flag clear.
// Flags are derived from the final selected result, so they always match res.
// No clock and no state. Assumes WIDTH >= 2.
module flag_alu
    import flag_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0]  op_a,
    input  logic [WIDTH-1:0]  op_b,
    input  logic [OP_W-1:0]   op_sel,
    output logic [WIDTH-1:0]  res,
    output logic [FLAG_W-1:0] flags
);

    alu_op_e          op;
    res_src_e         src;
    logic [WIDTH-1:0] arith_sum;
    logic             arith_carry;
    logic [WIDTH-1:0] mul_lo;
    logic [WIDTH-1:0] bit_out;

    // Present the raw code as the enumerated operation type.
    always_comb begin
        op = alu_op_e'(op_sel);
    end

    flag_alu_arith #(.WIDTH(WIDTH)) u_arith (
        .opnd_a (op_a),
        .opnd_b (op_b),
        .op     (op),
        .sum    (arith_sum),
        .carry  (arith_carry)
    );

    flag_alu_mul #(.WIDTH(WIDTH)) u_mul (
        .opnd_a  (op_a),
        .opnd_b  (op_b),
        .prod_lo (mul_lo)
    );

    flag_alu_bitwise #(.WIDTH(WIDTH)) u_bitwise (
        .opnd_a (op_a),
        .opnd_b (op_b),
        .op     (op),
        .out    (bit_out)
    );

    // Decode which unit supplies the result.
    always_comb begin
        if (!op_is_defined(op_sel)) begin
            src = SRC_NONE;
        end else if (op_uses_adder(op_sel)) begin
            src = SRC_ARITH;
        end else if (op == OP_MUL) begin
            src = SRC_MUL;
        end else begin
            src = SRC_BIT;
        end
    end

    // Final result multiplexer.
    always_comb begin
        case (src)
            SRC_ARITH: res = arith_sum;
            SRC_MUL:   res = mul_lo;
            SRC_BIT:   res = bit_out;
            default:   res = '0;
        endcase
    end

    // Derive the flags from the selected result.
    always_comb begin
        flags             = '0;
        flags[FLAG_ZERO]  = (src != SRC_NONE) && (res == '0);
        flags[FLAG_CARRY] = (src == SRC_ARITH) && arith_carry;
        flags[FLAG_SIGN]  = res[WIDTH-1];
    end

endmodule

// File: rtl/flag_alu_checker.sv
// Module: flag_alu_checker
// Watches the ports of flag_alu and checks port-level relations.
// Uses immediate assertions because the block has no clock.
// Attached to every flag_alu instance by the bind statement at the foot.
module flag_alu_checker #(
    parameter int WIDTH = 32
) (
    input logic [WIDTH-1:0] op_a,
    input logic [WIDTH-1:0] op_b,
    input logic [3:0]       op_sel,
    input logic [WIDTH-1:0] res,
    input logic [2:0]       flags
);

    // Check the output relations whenever any port changes.
    always_comb begin
        if (op_sel <= 4'd11) begin
            a_r8_zero_flag: assert (flags[0] == (res == '0))
                else $error("zero flag disagrees with result");
        end
        a_r9_sign_flag: assert (flags[2] == res[WIDTH-1])
            else $error("sign flag disagrees with result msb");
        if (op_sel == 4'd0 || (op_sel >= 4'd5 && op_sel <= 4'd11)) begin
            a_r10_no_carry: assert (flags[1] == 1'b0)
                else $error("carry set for a non-adder code");
        end
        if (op_sel >= 4'd12) begin
            a_r11_quiet_code: assert (res == '0 && flags == 3'b000)
                else $error("undefined code produced output");
        end
        if (op_sel == 4'd0) begin
            a_r1_pass_through: assert (res == op_a)
                else $error("pass did not copy operand a");
        end
        if (op_sel == 4'd9) begin
            a_r6_invert: assert (res == ~op_a)
                else $error("not did not invert operand a");
        end
        if (op_sel == 4'd1) begin
            a_r2_add_value: assert (res == op_a + op_b)
                else $error("add result wrong");
        end
    end

endmodule

bind flag_alu flag_alu_checker #(.WIDTH(WIDTH)) u_checker (
    .op_a   (op_a),
    .op_b   (op_b),
    .op_sel (op_sel),
    .res    (res),
    .flags  (flags)
);

// File: tb/flag_alu_bench.sv
// Directed bench for flag_alu: one 32-bit instance for boundary cases and
// one 8-bit instance swept against a reference model.
module flag_alu_bench;

    localparam int W_WIDE   = 32;
    localparam int W_NARROW = 8;

    logic clk = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [W_WIDE-1:0]   a32   = '0;
    logic [W_WIDE-1:0]   b32   = '0;
    logic [3:0]          sel32 = 4'd0;
    logic [W_WIDE-1:0]   r32;
    logic [2:0]          f32;

    logic [W_NARROW-1:0] a8    = '0;
    logic [W_NARROW-1:0] b8    = '0;
    logic [3:0]          sel8  = 4'd0;
    logic [W_NARROW-1:0] r8;
    logic [2:0]          f8;

    flag_alu #(.WIDTH(W_WIDE)) u_flag_alu (
        .op_a (a32), .op_b (b32), .op_sel (sel32), .res (r32), .flags (f32)
    );

    flag_alu #(.WIDTH(W_NARROW)) u_flag_alu_w8 (
        .op_a (a8), .op_b (b8), .op_sel (sel8), .res (r8), .flags (f8)
    );

    // Compare one value and log a failure line.
    task automatic check(input string tag, input string what,
                         input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, got, exp);
        end
    endtask

    // Reference model written from the requirements; flags = {sign, carry, zero}.
    function automatic void ref_alu(input int w, input logic [3:0] op,
                                    input logic [63:0] a, input logic [63:0] b,
                                    output logic [63:0] r, output logic [2:0] f);
        logic [63:0] mask;
        logic        c;
        mask = (64'd1 << w) - 64'd1;
        c    = 1'b0;
        case (op)
            4'd0:  r = a;
            4'd1:  begin r = (a + b) & mask; c = ((a + b) >> w) != 0; end
            4'd2:  begin r = (a - b) & mask; c = a < b; end
            4'd3:  begin r = (a + 1) & mask; c = a == mask; end
            4'd4:  begin r = (a - 1) & mask; c = a == 0; end
            4'd5:  r = (a * b) & mask;
            4'd6:  r = a & b;
            4'd7:  r = a | b;
            4'd8:  r = a ^ b;
            4'd9:  r = ~a & mask;
            4'd10: r = (a << 1) & mask;
            4'd11: r = a >> 1;
            default: r = 64'd0;
        endcase
        f[1] = c;
        f[2] = r[w-1];
        f[0] = (op <= 4'd11) && (r == 0);
    endfunction

    // Drive the wide instance and check result and flags.
    task automatic expect32(input string tag, input logic [3:0] op,
                            input logic [31:0] a, input logic [31:0] b,
                            input logic [31:0] exp_r, input logic [2:0] exp_f);
        @(posedge clk);
        sel32 = op; a32 = a; b32 = b;
        @(negedge clk);
        check(tag, "res", 64'(r32), 64'(exp_r));
        check(tag, "flags", 64'(f32), 64'(exp_f));
    endtask

    task automatic t_initial();
        @(negedge clk);
        check("R8", "initial res", 64'(r32), 64'd0);
        check("R8", "initial flags", 64'(f32), 64'b001);
    endtask

    task automatic t_pass();
        expect32("R1", 4'd0, 32'd22, 32'd0, 32'd22, 3'b000);
        expect32("R1", 4'd0, 32'h8000_0000, 32'd5, 32'h8000_0000, 3'b100);
    endtask

    task automatic t_add_sub();
        expect32("R2", 4'd1, 32'd12, 32'd13, 32'd25, 3'b000);
        expect32("R2", 4'd2, 32'd34, 32'd30, 32'd4, 3'b000);
        expect32("R2", 4'd1, 32'hFFFF_FF10, 32'hFFFF_FF10, 32'hFFFF_FE20, 3'b110);
        expect32("R8", 4'd2, 32'd10, 32'd10, 32'd0, 3'b001);
        expect32("R9", 4'd2, 32'hFFFF_FFFC, 32'd4, 32'hFFFF_FFF8, 3'b100);
        expect32("R2", 4'd2, 32'd3, 32'd5, 32'hFFFF_FFFE, 3'b110);
    endtask

    task automatic t_inc_dec();
        expect32("R3", 4'd3, 32'd1, 32'd0, 32'd2, 3'b000);
        expect32("R3", 4'd4, 32'd1, 32'd0, 32'd0, 3'b001);
        expect32("R3", 4'd3, 32'hFFFF_FFFF, 32'd0, 32'd0, 3'b011);
        expect32("R3", 4'd4, 32'd0, 32'd0, 32'hFFFF_FFFF, 3'b110);
    endtask

    task automatic t_mul();
        expect32("R4", 4'd5, 32'd3, 32'd5, 32'd15, 3'b000);
        expect32("R4", 4'd5, 32'h0001_0000, 32'h0001_0000, 32'd0, 3'b001);
        expect32("R4", 4'd5, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'd1, 3'b000);
    endtask

    task automatic t_logic();
        expect32("R5", 4'd6, 32'd2, 32'd3, 32'd2, 3'b000);
        expect32("R5", 4'd7, 32'd5, 32'd7, 32'd7, 3'b000);
        expect32("R5", 4'd8, 32'd11, 32'd9, 32'd2, 3'b000);
        expect32("R10", 4'd7, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'b100);
    endtask

    task automatic t_not();
        expect32("R6", 4'd9, 32'd10, 32'h1234_5678, 32'hFFFF_FFF5, 3'b100);
        expect32("R6", 4'd9, 32'hFFFF_FFFF, 32'd0, 32'd0, 3'b001);
    endtask

    task automatic t_shift();
        expect32("R7", 4'd10, 32'd2, 32'd0, 32'd4, 3'b000);
        expect32("R7", 4'd11, 32'd4, 32'd0, 32'd2, 3'b000);
        expect32("R7", 4'd10, 32'h8000_0001, 32'd0, 32'd2, 3'b000);
        expect32("R7", 4'd11, 32'h8000_0001, 32'd0, 32'h4000_0000, 3'b000);
        expect32("R10", 4'd10, 32'h8000_0000, 32'd0, 32'd0, 3'b001);
    endtask

    task automatic t_unused();
        for (int c = 12; c < 16; c++) begin
            expect32("R11", 4'(c), 32'd0, 32'd0, 32'd0, 3'b000);
            expect32("R11", 4'(c), 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'd0, 3'b000);
        end
    endtask

    // Operand b must not move the result of the unary codes.
    task automatic t_b_ignored();
        logic [3:0] ops [6] = '{4'd0, 4'd3, 4'd4, 4'd9, 4'd10, 4'd11};
        logic [31:0] ra;
        logic [2:0]  fa;
        for (int i = 0; i < 6; i++) begin
            @(posedge clk);
            sel32 = ops[i]; a32 = 32'h0F0F_8001; b32 = 32'd0;
            @(negedge clk);
            ra = r32; fa = f32;
            @(posedge clk);
            b32 = 32'hDEAD_BEEF;
            @(negedge clk);
            check("R12", "res vs b", 64'(r32), 64'(ra));
            check("R12", "flags vs b", 64'(f32), 64'(fa));
        end
    endtask

    // Narrow instance: every a under every code against the reference model.
    task automatic t_sweep8();
        logic [63:0] er;
        logic [2:0]  ef;
        for (int c = 0; c < 16; c++) begin
            for (int v = 0; v < 256; v++) begin
                @(posedge clk);
                sel8 = 4'(c);
                a8   = 8'(v);
                b8   = 8'(v) ^ 8'h3C ^ {8'(v)} << 3;
                @(negedge clk);
                ref_alu(W_NARROW, 4'(c), 64'(a8), 64'(b8), er, ef);
                check("R8 R9 R10 sweep", "res8", 64'(r8), er);
                check("R8 R9 R10 sweep", "flags8", 64'(f8), 64'(ef));
            end
        end
    endtask

    initial begin
        t_initial();
        t_pass();
        t_add_sub();
        t_inc_dec();
        t_mul();
        t_logic();
        t_not();
        t_shift();
        t_unused();
        t_b_ignored();
        t_sweep8();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // Watchdog: a hung run is recorded as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule